// File: doc/BRIEF.md
# Trinomial modular reduction unit

This block takes the unreduced carry-less product of two elements of GF(2^m), a polynomial of degree at most 2m-2 held in 2m-1 bits, and reduces it modulo a fixed irreducible trinomial x^m + x^n + 1. The result is the m-bit field element. Together with a carry-less polynomial multiplier in front of it, it forms a complete binary-field multiplier for elliptic-curve arithmetic.

The reduction is pure XOR logic. It uses x^m = x^n + 1. Every coefficient at position i >= m is folded down to positions i-m and i-m+n. One fold pass leaves a few bits above m-1, which come from the top of the high part shifted up by n. A second, much narrower pass clears them. The second pass is generated only when the first pass leaves such bits. The field size m and the middle exponent n are parameters, with defaults 191 and 9. An optional output register with a valid flag sits after the XOR network.

Top module: `trired_top`

## Requirements
- R1: For any 2m-1 bit input, res_o equals the input polynomial modulo x^m + x^n + 1 (default m = 191, n = 9). Bit i of prod_i is the coefficient of x^i, and bit j of res_o is the coefficient of x^j.
- R2: A lone coefficient at x^m reduces to x^n + 1. A lone coefficient at the top position x^(2m-2) reduces to the same value as bitwise long division gives; for n >= 2 this needs the second fold.
- R3: With m = 4 and n = 1, the input 7'b0110100 (the product of x^3+x^2+1 and x^2) reduces to 4'b0001. Random 7-bit inputs match long division.
- R4: An input whose bits at positions m and above are all zero appears unchanged on res_o.
- R5: With the output register enabled, out_valid_o is high exactly in the cycle after a cycle with in_valid_i high, and low after a cycle with in_valid_i low.
- R6: With the output register enabled, res_o keeps its value while in_valid_i is low, whatever prod_i holds.
- R7: While rst_ni is low, out_valid_o and res_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | prod_i holds a product to reduce |
| prod_i | input | 2*M-1 | Unreduced product, bit i is the coefficient of x^i |
| out_valid_o | output | 1 | res_o holds a fresh result |
| res_o | output | M | Reduced field element |

## Verification
The hardest case to reach is a product whose top coefficients are set. Only those bits drive the second fold, and random stimulus rarely isolates them. The bench applies single-bit inputs at x^m and at x^(2m-2), and an all-ones input, at the default size. It also runs the small m = 4, n = 1 field, where the reduction can be checked by hand. Every other result is compared with a bitwise long-division model over random full-width inputs at both sizes.

// File: rtl/trired_pkg.sv
package trired_pkg;
  // width left after folding an in_w-bit polynomial once
  function automatic int fold_w(input int in_w, input int m, input int n);
    int hi_top;
    hi_top = in_w - m + n;
    return (hi_top > m) ? hi_top : m;
  endfunction
endpackage

// File: rtl/trired_fold.sv
module trired_fold #(
  parameter int IN_W = 381,
  parameter int M    = 191,
  parameter int N    = 9,
  localparam int OW  = trired_pkg::fold_w(IN_W, M, N)
) (
  input  logic [IN_W-1:0] c_i,
  output logic [OW-1:0]   c_o
);
  logic [OW-1:0] lo_x, hi_x, hs_x;

  assign lo_x = OW'(c_i[M-1:0]);
  assign hi_x = OW'(c_i[IN_W-1:M]);
  assign hs_x = hi_x << N;            // x^m -> x^n + 1
  assign c_o  = lo_x ^ hi_x ^ hs_x;
endmodule

// File: rtl/trired_out.sv
module trired_out #(
  parameter int W       = 191,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        q_o     <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) q_o <= d_i;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign valid_o = valid_i;
    assign q_o     = d_i;
  end
endmodule

// File: rtl/trired_top.sv
module trired_top #(
  parameter int M       = 191,
  parameter int N       = 9,
  parameter bit REG_OUT = 1'b1,
  localparam int PW     = 2*M - 1,
  localparam int W1     = trired_pkg::fold_w(PW, M, N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [PW-1:0] prod_i,
  output logic          out_valid_o,
  output logic [M-1:0]  res_o
);
  logic [W1-1:0] f1_w;
  logic [M-1:0]  red_w;

  trired_fold #(.IN_W(PW), .M(M), .N(N)) u_fold1 (
    .c_i (prod_i),
    .c_o (f1_w)
  );

  if (W1 > M) begin : g_fold2
    localparam int W2 = trired_pkg::fold_w(W1, M, N);
    logic [W2-1:0] f2_w;
    trired_fold #(.IN_W(W1), .M(M), .N(N)) u_fold2 (
      .c_i (f1_w),
      .c_o (f2_w)
    );
    assign red_w = f2_w[M-1:0];
  end else begin : g_nofold2
    assign red_w = f1_w[M-1:0];
  end

  trired_out #(.W(M), .REG_OUT(REG_OUT)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .d_i     (red_w),
    .valid_o (out_valid_o),
    .q_o     (res_o)
  );
endmodule

// File: rtl/trired_chk.sv
module trired_chk #(
  parameter int M       = 191,
  parameter int N       = 9,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           in_valid_i,
  input logic [2*M-2:0] prod_i,
  input logic           out_valid_o,
  input logic [M-1:0]   res_o
);
  localparam logic [M-1:0] XM_RED = M'((1 << N) | 1);

  if (REG_OUT) begin : g_seq
    p_valid_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> out_valid_o);
    p_valid_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> !out_valid_o);
    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> $stable(res_o));
    p_passthru_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && prod_i[2*M-2:M] == '0) |=> res_o == $past(prod_i[M-1:0]));
    p_xm_fold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && prod_i == (2*M-1)'(1) << M) |=> res_o == XM_RED);
  end
endmodule

bind trired_top trired_chk #(.M(M), .N(N), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_trired_top.sv
module tb_trired_top;
  localparam int M  = 191;
  localparam int N  = 9;
  localparam int PW = 2*M - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          vld_i = 1'b0;
  logic [PW-1:0] prod = '0;
  logic          vld_o;
  logic [M-1:0]  res;

  logic          s_vld_i = 1'b0;
  logic [6:0]    s_prod = '0;
  logic          s_vld_o;
  logic [3:0]    s_res;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  trired_top #(.M(M), .N(N), .REG_OUT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vld_i), .prod_i(prod),
    .out_valid_o(vld_o), .res_o(res)
  );

  trired_top #(.M(4), .N(1), .REG_OUT(1'b1)) dut_small (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(s_vld_i), .prod_i(s_prod),
    .out_valid_o(s_vld_o), .res_o(s_res)
  );

  function automatic logic [M-1:0] ref_mod(input logic [PW-1:0] p, input int m, input int n);
    logic [PW-1:0] t;
    logic [M-1:0] r;
    t = p;
    for (int i = 2*m-2; i >= m; i--) begin
      if (t[i]) begin
        t[i]       = 1'b0;
        t[i-m]     = ~t[i-m];
        t[i-m+n]   = ~t[i-m+n];
      end
    end
    r = '0;
    for (int i = 0; i < m; i++) r[i] = t[i];
    return r;
  endfunction

  function automatic logic [PW-1:0] rnd_prod();
    logic [PW-1:0] v;
    v = '0;
    for (int k = 0; k < 12; k++) v = {v[PW-33:0], 32'($urandom)};
    return v;
  endfunction

  task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_big(input string req, input logic [PW-1:0] p);
    @(negedge clk);
    prod  = p;
    vld_i = 1'b1;
    @(negedge clk);
    vld_i = 1'b0;
    check(req, res, ref_mod(p, M, N));
    check("R5 valid", M'(vld_o), M'(1));
  endtask

  task automatic run_small(input string req, input logic [6:0] p, input logic [3:0] exp);
    @(negedge clk);
    s_prod  = p;
    s_vld_i = 1'b1;
    @(negedge clk);
    s_vld_i = 1'b0;
    check(req, M'(s_res), M'(exp));
  endtask

  task automatic t_reset();
    #1;
    check("R7 out_valid", M'(vld_o), '0);
    check("R7 res", res, '0);
    check("R7 small res", M'(s_res), '0);
  endtask

  task automatic t_single_bits();
    logic [PW-1:0] one = PW'(1);
    run_big("R2 x^m", one << M);
    check("R2 x^m literal", res, M'((1 << N) | 1));
    run_big("R2 top bit", one << (PW-1));
    run_big("R2 bit m+1", one << (M+1));
    run_big("R2 all ones", '1);
    run_big("R1 zero", '0);
  endtask

  task automatic t_passthru();
    for (int k = 0; k < 4; k++) begin
      logic [PW-1:0] p;
      p = rnd_prod();
      p[PW-1:M] = '0;
      run_big("R4 passthrough", p);
      check("R4 passthrough literal", res, p[M-1:0]);
    end
  endtask

  task automatic t_random_big();
    for (int k = 0; k < 40; k++) run_big("R1 random", rnd_prod());
  endtask

  task automatic t_small();
    run_small("R3 known product", 7'b0110100, 4'b0001);
    run_small("R3 x^4", 7'b0010000, 4'b0011);
    for (int k = 0; k < 30; k++) begin
      logic [6:0] p;
      logic [M-1:0] e;
      p = 7'($urandom);
      e = ref_mod(PW'(p), 4, 1);
      run_small("R3 random", p, e[3:0]);
    end
  endtask

  task automatic t_valid_hold();
    logic [M-1:0] held;
    run_big("R1 before hold", rnd_prod());
    held = res;
    @(negedge clk);
    prod = rnd_prod();
    @(negedge clk);
    check("R5 valid drop", M'(vld_o), '0);
    check("R6 hold", res, held);
    prod = '1;
    @(negedge clk);
    check("R6 hold after change", res, held);
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_single_bits();
    t_passthru();
    t_random_big();
    t_small();
    t_valid_hold();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule